// File: doc/BRIEF.md
# Masked Interrupt Line Aggregator

The block collects sixteen board-level interrupt request pins and presents them to a processor as four active-high request lines. Every pin passes through a synchroniser and sets a pending flag. Pins 0 to 14 are low-active level sources, so their flags follow the pin. Pin 15 is a falling-edge source meant for a non-maskable push button, and its flag holds until software clears it. A 16-bit mask register gates the flags. Each output line is the OR of the unmasked flags that lie in a fixed routing set for that line.

Software reaches the block through a small register port with select, write strobe, byte offset and data. It can read and write the mask and read the flags. It clears flags by writing zeros, so a one in the written word leaves that flag as it was. A registered index of the highest-numbered unmasked pending source lets the service routine handle requests from the top down without scanning.

Top module: `irq_route_agg`

## Requirements
- R1: After reset the mask reads 0xFFFF, the flags read 0x0000, and all four lines and `top_valid` are low.
- R2: The mask register is at offset 0x4 and can be read and written as 16 bits. Reading offset 0xC returns the raw flags, masked bits included.
- R3: For pins 0 to 14, a low pin sets its flag and a high pin leaves it clear.
- R4: A zero written to the flag bit of a level pin that is still low leaves that flag set.
- R5: A falling edge on pin 15 sets flag bit 15, and the flag stays set after the pin returns high.
- R6: Writing a word to offset 0xC clears flag 15 when bit 15 of the word is 0. It keeps flag 15 when that bit is 1, so writing 0xFFFF clears nothing.
- R7: If a falling edge on pin 15 and a clear of bit 15 arrive in the same cycle, the flag ends up set.
- R8: A mask bit of 1 keeps its flag off every line and out of the index. A mask bit of 0 lets the flag through.
- R9: Line k goes high exactly when (flags AND NOT mask AND route_k) is non-zero. The routing sets are 0x0028 for line 0, 0x0050 for line 1, 0x1C00 for line 2 and 0x6386 for line 3. Bits 0 and 15 are on no line.
- R10: `top_idx` holds the highest bit number set in (flags AND NOT mask), and `top_valid` shows that this value is non-zero. Unrouted bits count.
- R11: A pin change reaches its flag on the third rising clock edge. The lines and the index follow one edge after the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_pin_n | input | 16 | Interrupt pins, low-active; bit 15 is the edge source |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte offset into the register window |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational, zero when not selected) |
| line_irq | output | 4 | Routed request lines, active-high |
| top_idx | output | 4 | Highest unmasked pending source number |
| top_valid | output | 1 | Some unmasked flag is pending |

## Verification
Every cycle, the assertions check four things. Flag 15 stays set until a zero is written to it. A falling edge always lands in the flag. A low level pin always shows up in its flag. Each line and the index can only report flags that were unmasked and, for a line, routed on the previous cycle. Other behaviour only shows up in the bench's scenarios: the reset values, the register offsets, the exact latency, an edge beating a clear in the same cycle, and a line staying low when its inputs are masked. The bench checks these with directed pulses and with random mixes of pins, masks and clear words.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned NSRC  = 16;
  localparam int unsigned NLINE = 4;
  localparam int unsigned AW    = 4;
  localparam logic [AW-1:0]   MASK_OFS = 4'h4;
  localparam logic [AW-1:0]   FLAG_OFS = 4'hC;
  localparam logic [NSRC-1:0] EDGE_SRC = 16'h8000;
  localparam logic [NSRC-1:0] MASK_RST = 16'hFFFF;

  // fixed source set feeding each request line
  function automatic logic [NSRC-1:0] line_route(input int unsigned k);
    case (k)
      0:       line_route = 16'h0028;
      1:       line_route = 16'h0050;
      2:       line_route = 16'h1C00;
      3:       line_route = 16'h6386;
      default: line_route = '0;
    endcase
  endfunction
endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
  parameter int unsigned     N        = 16,
  parameter int unsigned     SYNC     = 2,
  parameter logic [N-1:0]    EDGE_MAP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_n,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] sync_q [SYNC];
  logic [N-1:0] pin_s;
  logic [N-1:0] prev_q;
  logic [N-1:0] flag_q, flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC; s++) sync_q[s] <= '1;
    end else begin
      sync_q[0] <= pin_n;
      for (int s = 1; s < SYNC; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign pin_s = sync_q[SYNC-1];

  for (genvar i = 0; i < N; i++) begin : g_src
    if (EDGE_MAP[i]) begin : g_edge
      always_comb flag_d[i] = (prev_q[i] & ~pin_s[i]) | (flag_q[i] & ~clr[i]);

      AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q[i] && !clr[i] |=> flag_q[i]); // R5
      AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        prev_q[i] && !pin_s[i] |=> flag_q[i]); // R7
    end else begin : g_level
      always_comb flag_d[i] = ~pin_s[i];

      AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_s[i] |=> flag_q[i]); // R4
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      flag_q <= '0;
    end else begin
      prev_q <= pin_s;
      flag_q <= flag_d;
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
  parameter int unsigned N = 16,
  parameter int unsigned L = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] active,
  output logic [L-1:0] irq_o
);
  logic [L-1:0] hit_d, hit_q;

  for (genvar k = 0; k < L; k++) begin : g_line
    assign hit_d[k] = |(active & N'(irq_route_pkg::line_route(k)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= '0;
    else        hit_q <= hit_d;
  end

  assign irq_o = hit_q;
endmodule

// File: rtl/irq_top_pick.sv
module irq_top_pick #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  active,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  logic [IW-1:0] idx_d, idx_q;
  logic          valid_q;

  always_comb begin
    idx_d = '0;
    for (int i = 0; i < N; i++)
      if (active[i]) idx_d = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      valid_q <= |active;
    end
  end

  assign idx_o   = idx_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/irq_route_agg.sv
module irq_route_agg
  import irq_route_pkg::*;
#(
  parameter int unsigned N    = NSRC,
  parameter int unsigned L    = NLINE,
  parameter int unsigned SYNC = 2,
  localparam int unsigned IW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_pin_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [N-1:0]  reg_wdata,
  output logic [N-1:0]  reg_rdata,
  output logic [L-1:0]  line_irq,
  output logic [IW-1:0] top_idx,
  output logic          top_valid
);
  logic         rst_meta_q, rst_ok_q;
  logic [N-1:0] mask_q, mask_d;
  logic         mask_we, flag_wr;
  logic [N-1:0] clr, flags, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ok_q   <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ok_q   <= rst_meta_q;
    end
  end

  assign mask_we = reg_sel & reg_wr & (reg_addr == MASK_OFS);
  assign flag_wr = reg_sel & reg_wr & (reg_addr == FLAG_OFS);
  assign clr     = flag_wr ? ~reg_wdata : '0;

  always_comb begin
    mask_d = mask_q;
    if (mask_we) mask_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_ok_q) begin
    if (!rst_ok_q) mask_q <= N'(MASK_RST);
    else           mask_q <= mask_d;
  end

  irq_src_capture #(.N(N), .SYNC(SYNC), .EDGE_MAP(N'(EDGE_SRC))) u_cap (
    .clk(clk), .rst_n(rst_ok_q), .pin_n(irq_pin_n), .clr(clr), .flags(flags));

  assign active = flags & ~mask_q;

  irq_line_merge #(.N(N), .L(L)) u_merge (
    .clk(clk), .rst_n(rst_ok_q), .active(active), .irq_o(line_irq));

  irq_top_pick #(.N(N)) u_pick (
    .clk(clk), .rst_n(rst_ok_q), .active(active), .idx_o(top_idx), .valid_o(top_valid));

  always_comb begin
    reg_rdata = '0;
    if (reg_sel && !reg_wr) begin
      if (reg_addr == MASK_OFS)      reg_rdata = mask_q;
      else if (reg_addr == FLAG_OFS) reg_rdata = flags;
    end
  end

  for (genvar k = 0; k < L; k++) begin : g_chk
    AST_LINE_GATED: assert property (@(posedge clk) disable iff (!rst_ok_q)
      line_irq[k] |-> $past(|(flags & ~mask_q & N'(line_route(k))))); // R9
  end

  AST_ONES_KEEP: assert property (@(posedge clk) disable iff (!rst_ok_q)
    flag_wr && reg_wdata[N-1] && flags[N-1] |=> flags[N-1]); // R6

  AST_TOP_HIGHEST: assert property (@(posedge clk) disable iff (!rst_ok_q)
    top_valid |-> ($past(flags & ~mask_q) >> top_idx) == N'(1)); // R10
endmodule

// File: tb/irq_route_agg_test.sv
module irq_route_agg_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_pin_n;
  logic        reg_sel, reg_wr;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [3:0]  line_irq, top_idx;
  logic        top_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] pins_m, mask_m;
  logic        edge_m;
  logic [15:0] rv;

  always #2 clk = ~clk;

  irq_route_agg uut (.*);

  function automatic logic [15:0] route(int k);
    case (k) 0: return 16'h0028; 1: return 16'h0050; 2: return 16'h1C00; default: return 16'h6386; endcase
  endfunction
  function automatic logic [15:0] exp_flags();
    return {edge_m, ~pins_m[14:0]};
  endfunction
  function automatic logic [3:0] exp_lines();
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = |(exp_flags() & ~mask_m & route(k));
    return r;
  endfunction
  function automatic logic [3:0] exp_idx();
    logic [3:0] r = '0;
    logic [15:0] a = exp_flags() & ~mask_m;
    for (int i = 0; i < 16; i++) if (a[i]) r = 4'(i);
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_sel = 0; reg_wr = 0;
  endtask
  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_sel = 1; reg_wr = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_sel = 0;
  endtask
  task automatic settle(); repeat (6) @(negedge clk); endtask
  task automatic set_pins(logic [15:0] p);
    @(negedge clk);
    if (pins_m[15] && !p[15]) edge_m = 1;
    irq_pin_n = p; pins_m = p;
  endtask
  task automatic check_all(string tag);
    rd(4'hC, rv);
    check({tag, " flags"}, rv, exp_flags());
    check({tag, " lines"}, line_irq, exp_lines());
    check({tag, " valid"}, top_valid, |(exp_flags() & ~mask_m));
    if (|(exp_flags() & ~mask_m)) check({tag, " idx"}, top_idx, exp_idx());
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; irq_pin_n = '1; pins_m = '1; mask_m = '1; edge_m = 0;
    reg_sel = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(4'h4, rv); check("R1 mask", rv, 16'hFFFF);
    rd(4'hC, rv); check("R1 flags", rv, 16'h0000);
    check("R1 lines", line_irq, 4'h0);
    check("R1 valid", top_valid, 1'b0);

    // R2 mask register access
    wr(4'h4, 16'h7FFE); mask_m = 16'h7FFE;
    rd(4'h4, rv); check("R2 mask rw", rv, 16'h7FFE);

    // R3 / R8 level pin masked: flag visible, no line
    set_pins(16'hFFF7); settle();
    check_all("R3 R8 masked level");
    // R9 each level pin routed alone with mask open
    wr(4'h4, 16'h0000); mask_m = 16'h0000;
    for (int i = 0; i < 15; i++) begin
      set_pins(~(16'h1 << i)); settle();
      check_all($sformatf("R9 R10 src%0d", i));
    end
    // R4 clear of low level pin has no lasting effect
    set_pins(16'hFFDF); settle();
    wr(4'hC, 16'h0000); settle();
    rd(4'hC, rv); check("R4 level reasserts", rv[5], 1'b1);

    // R11 latency: flag on third edge, line one edge later
    set_pins(16'hFFFF); settle();
    @(negedge clk); irq_pin_n = 16'hFFDF; pins_m = 16'hFFDF;
    @(posedge clk); @(posedge clk);
    @(negedge clk); check("R11 line before", line_irq[0], 1'b0);
    reg_sel = 1; reg_wr = 0; reg_addr = 4'hC; #1 check("R11 flag pre", reg_rdata[5], 1'b0);
    @(negedge clk); #1 check("R11 flag at 3rd edge", reg_rdata[5], 1'b1);
    check("R11 line lags", line_irq[0], 1'b0);
    reg_sel = 0;
    @(negedge clk); check("R11 line after", line_irq[0], 1'b1);
    set_pins(16'hFFFF); settle();

    // R5 edge capture sticky
    set_pins(16'h7FFF); settle();
    set_pins(16'hFFFF); settle();
    check_all("R5 edge sticky");
    check("R10 unrouted top", top_idx, 4'd15);
    // R6 ones keep, zero clears
    wr(4'hC, 16'hFFFF); settle(); check_all("R6 ones keep");
    wr(4'hC, 16'h7FFF); edge_m = 0; settle(); check_all("R6 zero clears");

    // R7 edge and clear in the same cycle
    @(negedge clk); irq_pin_n = 16'h7FFF; pins_m = 16'h7FFF; edge_m = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_sel = 1; reg_wr = 1; reg_addr = 4'hC; reg_wdata = 16'h0000;
    @(negedge clk); reg_sel = 0; reg_wr = 0;
    settle(); check_all("R7 edge wins");
    set_pins(16'hFFFF); settle();

    // random mixes
    for (int it = 0; it < 60; it++) begin
      set_pins(16'($urandom));
      settle();
      if ($urandom_range(0, 1)) begin
        mask_m = 16'($urandom);
        wr(4'h4, mask_m);
      end
      if ($urandom_range(0, 1)) begin
        rv = 16'($urandom);
        wr(4'hC, rv);
        if (!rv[15]) edge_m = 0;
      end
      settle();
      check_all($sformatf("R3 R6 R8 R9 R10 rnd%0d", it));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule